// File: doc/BRIEF.md
# Multiplexed Byte-Lane Burst Write Controller

This block performs writes to asynchronous external memory, or to memory-mapped devices, over a 16-bit bus that carries address and data on the same lines. One request holds a 16-bit base address, a 32-bit word and the timing settings for that write. The controller first shows the full address while an address-latch strobe is active. It then splits the word into four bytes and writes them one after another. During each write the byte sits on the low half of the bus and the upper address byte sits on the high half. All bus timing is counted in cycles of the controller clock.

The length of each write pulse, the gap between pulses and the hold time after each pulse all come from a 5-bit duration value, a hold enable and a flash-mode enable. Flash mode makes the gap between pulses longer and takes the same amount off the pulse itself. A request whose settings cannot be met is refused: a one-cycle error pulse appears and the bus is not touched. A single input selects the polarity of the address-latch strobe. Its inactive level after reset is low, which makes the strobe active high.

Top module: `mux_byte_writer`

## Requirements
- R1: After reset, busy, done and err are 0, bus_wr_n and bus_rd_n are 1, bus_ad_oe is 0, bus_ad_out is 0 and bus_ale is at its inactive level.
- R2: A legal request sampled while idle makes the latch strobe active for exactly 2 cycles, starting in the cycle after acceptance. During those cycles bus_ad_out carries the full 16-bit address, bus_ad_oe is 1 and busy is 1.
- R3: For 1 cycle after the latch strobe ends, bus_ad_out still carries the full address. bus_wr_n first goes low 2 cycles after the strobe ends, and never while the strobe is active.
- R4: With duration value D and flash stretch F (F=7 when flash mode is on, else 0), each bus_wr_n low pulse lasts D-F cycles.
- R5: Between two latch strobes there are exactly four write pulses. Pulse k (k=0..3) carries bits [8k+7:8k] of the word on bus_ad_out[7:0], so the least-significant byte goes first.
- R6: Whenever a byte is on the bus, bus_ad_out[15:8] equals address bits [15:8]. With the hold enable set, the byte and the upper address stay on the bus for 1 cycle after bus_wr_n rises. Without it they change in the cycle it rises.
- R7: From a rising edge of bus_wr_n to the next falling edge there are F+H+1 cycles, where H is 1 if the hold enable is set and 0 otherwise.
- R8: H cycles after the last write pulse ends, done is 1 for exactly one cycle. In that same cycle busy and bus_ad_oe drop to 0 and bus_ad_out returns to 0.
- R9: bus_ale equals cfg_ale_low when inactive and its inverse when active. The level follows cfg_ale_low one cycle later while idle. cfg_ale_low must be held steady during a transaction.
- R10: A request is illegal if the duration value is below 2, or if flash mode is on and the duration value is not 9. An illegal request sampled while idle gives err=1 for one cycle with busy, bus_ad_oe and bus_wr_n unchanged from idle.
- R11: bus_rd_n stays 1 at all times.
- R12: req_valid seen while busy is ignored, so the running transaction's bus sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | 16 | Base address |
| req_data | input | 32 | Word to write, sent as four bytes |
| cfg_dur | input | 5 | Write duration value in cycles |
| cfg_hold | input | 1 | Adds one hold cycle after each write pulse |
| cfg_flash | input | 1 | Flash mode: shortens the pulse by 7 and lengthens the gap by 7 |
| cfg_ale_low | input | 1 | 1 makes the latch strobe active low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when a transaction ends |
| err | output | 1 | One-cycle pulse when a request is refused |
| bus_ad_out | output | 16 | Value driven onto the shared address/data lines |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ale | output | 1 | Address-latch strobe |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low, held inactive |

## Verification
The bench checks every cycle of a transaction against a timeline it computes from D, F and H. It covers the shortest legal pulse (D=2), flash mode with its seven-cycle stretch, and hold on and off. A design that miscounts the pulse, the gap or the hold gets out of step with that timeline: it moves a byte change or a strobe edge by a cycle, or ends done one cycle early or late. A design with the lanes in the wrong order, or one that stops after three or goes on to five writes, puts a wrong byte on bus_ad_out[7:0]. Refused settings (D=1, and flash with D≠9) must raise err and leave the bus untouched. A second request during a running transaction must not change its sequence. A design that gets the latch polarity backwards shows the wrong idle level on bus_ale.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

    localparam int ADDR_W        = 16;
    localparam int LANE_W        = 8;
    localparam int LANES         = 4;
    localparam int WORD_W        = LANE_W * LANES;
    localparam int IDX_W         = $clog2(LANES);
    localparam int DUR_W         = 5;
    localparam int ALE_CYCLES    = 2;
    localparam int MIN_DUR       = 2;
    localparam int FLASH_DUR     = 9;
    localparam int FLASH_STRETCH = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_AHOLD,
        ST_SETUP,
        ST_WRLOW,
        ST_WHOLD
    } mwr_state_e;

    typedef struct packed {
        mwr_state_e         state;
        logic [DUR_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic [ADDR_W-1:0]  addr;
        logic [WORD_W-1:0]  data;
        logic [DUR_W-1:0]   wlow;
        logic [DUR_W-1:0]   stretch;
        logic               hold;
    } mwr_ctl_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  ad;
        logic               oe;
        logic               ale;
        logic               wr_n;
        logic               busy;
        logic               done;
        logic               err;
    } mwr_out_t;

endpackage

// File: rtl/mwr_cfg_check.sv
module mwr_cfg_check
    import mwr_pkg::*;
(
    input  logic [DUR_W-1:0] dur,
    input  logic             flash,
    output logic             legal,
    output logic [DUR_W-1:0] wlow,
    output logic [DUR_W-1:0] stretch
);

    localparam logic [DUR_W-1:0] MinDur   = DUR_W'(MIN_DUR);
    localparam logic [DUR_W-1:0] FlashDur = DUR_W'(FLASH_DUR);
    localparam logic [DUR_W-1:0] FlashStr = DUR_W'(FLASH_STRETCH);

    always_comb begin
        legal   = (dur >= MinDur) && (!flash || (dur == FlashDur));
        stretch = flash ? FlashStr : '0;
        wlow    = dur - stretch;
    end

endmodule

// File: rtl/mwr_lane_sel.sv
module mwr_lane_sel #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES*LANE_W-1:0] word,
    input  logic [SEL_W-1:0]        sel,
    output logic [LANE_W-1:0]       lane
);

    logic [LANE_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*LANE_W +: LANE_W];
    end

    assign lane = lanes[sel];

endmodule

// File: rtl/mux_byte_writer.sv
module mux_byte_writer
    import mwr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [WORD_W-1:0]   req_data,
    input  logic [DUR_W-1:0]    cfg_dur,
    input  logic                cfg_hold,
    input  logic                cfg_flash,
    input  logic                cfg_ale_low,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [ADDR_W-1:0]   bus_ad_out,
    output logic                bus_ad_oe,
    output logic                bus_ale,
    output logic                bus_wr_n,
    output logic                bus_rd_n
);

    localparam logic [IDX_W-1:0] LastIdx = IDX_W'(LANES - 1);
    localparam int               HiW     = ADDR_W - LANE_W;

    mwr_ctl_t ctl_d, ctl_q;
    mwr_out_t out_d, out_q;

    logic             req_legal;
    logic [DUR_W-1:0] req_wlow;
    logic [DUR_W-1:0] req_stretch;
    logic [LANE_W-1:0] lane_byte;

    mwr_cfg_check u_cfg (
        .dur     (cfg_dur),
        .flash   (cfg_flash),
        .legal   (req_legal),
        .wlow    (req_wlow),
        .stretch (req_stretch)
    );

    mwr_lane_sel #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_lane (
        .word (ctl_d.data),
        .sel  (ctl_d.idx),
        .lane (lane_byte)
    );

    logic finish_err;
    logic finish_done;

    // next control state
    always_comb begin
        ctl_d       = ctl_q;
        finish_err  = 1'b0;
        finish_done = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_legal) begin
                        ctl_d.state   = ST_ALE;
                        ctl_d.cnt     = DUR_W'(ALE_CYCLES - 1);
                        ctl_d.idx     = '0;
                        ctl_d.addr    = req_addr;
                        ctl_d.data    = req_data;
                        ctl_d.wlow    = req_wlow;
                        ctl_d.stretch = req_stretch;
                        ctl_d.hold    = cfg_hold;
                    end else begin
                        finish_err = 1'b1;
                    end
                end
            end
            ST_ALE: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.state = ST_AHOLD;
                    ctl_d.cnt   = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_AHOLD: begin
                ctl_d.state = ST_SETUP;
                ctl_d.cnt   = '0;
            end
            ST_SETUP: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.state = ST_WRLOW;
                    ctl_d.cnt   = ctl_q.wlow - 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_WRLOW, ST_WHOLD: begin
                if (ctl_q.state == ST_WRLOW && ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else if (ctl_q.state == ST_WRLOW && ctl_q.hold) begin
                    ctl_d.state = ST_WHOLD;
                    ctl_d.cnt   = '0;
                end else if (ctl_q.idx == LastIdx) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.cnt   = '0;
                    finish_done = 1'b1;
                end else begin
                    ctl_d.state = ST_SETUP;
                    ctl_d.idx   = ctl_q.idx + 1'b1;
                    ctl_d.cnt   = ctl_q.stretch;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    // next registered bus outputs, decoded from the next state
    always_comb begin
        out_d      = '0;
        out_d.wr_n = 1'b1;
        out_d.err  = finish_err;
        out_d.done = finish_done;
        out_d.busy = (ctl_d.state != ST_IDLE);
        out_d.oe   = (ctl_d.state != ST_IDLE);
        out_d.ale  = (ctl_d.state == ST_ALE) ^ cfg_ale_low;
        unique case (ctl_d.state)
            ST_ALE, ST_AHOLD:            out_d.ad = ctl_d.addr;
            ST_SETUP, ST_WHOLD:          out_d.ad = {ctl_d.addr[ADDR_W-1 -: HiW], lane_byte};
            ST_WRLOW: begin
                out_d.ad   = {ctl_d.addr[ADDR_W-1 -: HiW], lane_byte};
                out_d.wr_n = 1'b0;
            end
            default:                     out_d.ad = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            out_q       <= '0;
            out_q.wr_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
            out_q <= out_d;
        end
    end

    assign busy       = out_q.busy;
    assign done       = out_q.done;
    assign err        = out_q.err;
    assign bus_ad_out = out_q.ad;
    assign bus_ad_oe  = out_q.oe;
    assign bus_ale    = out_q.ale;
    assign bus_wr_n   = out_q.wr_n;
    assign bus_rd_n   = 1'b1;

endmodule

// File: rtl/mwr_checker.sv
module mwr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_ale_low,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [15:0] bus_ad_out,
    input logic        bus_ad_oe,
    input logic        bus_ale,
    input logic        bus_wr_n,
    input logic        bus_rd_n
);

    logic       ale_act;
    logic       busy_prev;
    logic       wr_prev;
    logic [3:0] wr_cnt;

    assign ale_act = bus_ale ^ cfg_ale_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_prev <= 1'b0;
            wr_prev   <= 1'b1;
            wr_cnt    <= '0;
        end else begin
            busy_prev <= busy;
            wr_prev   <= bus_wr_n;
            if (busy && !busy_prev)
                wr_cnt <= '0;
            else if (!bus_wr_n && wr_prev)
                wr_cnt <= wr_cnt + 1'b1;
        end
    end

    assert_ale_two_cycles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ale_act ##1 ale_act ##1 !ale_act);

    assert_addr_after_ale_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(ale_act)) |-> $stable(bus_ad_out));

    assert_no_wr_in_ale_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> (!ale_act && bus_ad_oe));

    assert_four_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_cnt == 4'd4));

    assert_upper_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_wr_n) && busy) |-> $stable(bus_ad_out[15:8]));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !bus_ad_oe && bus_wr_n));

    assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_n);

endmodule

bind mux_byte_writer mwr_checker u_mwr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ale_low (cfg_ale_low),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .bus_ad_out  (bus_ad_out),
    .bus_ad_oe   (bus_ad_oe),
    .bus_ale     (bus_ale),
    .bus_wr_n    (bus_wr_n),
    .bus_rd_n    (bus_rd_n)
);

// File: tb/mux_byte_writer_bench.sv
module mux_byte_writer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [4:0]  cfg_dur = 5'd3;
    logic        cfg_hold = 1'b0;
    logic        cfg_flash = 1'b0;
    logic        cfg_ale_low = 1'b0;
    logic        busy, done, err, bus_ad_oe, bus_ale, bus_wr_n, bus_rd_n;
    logic [15:0] bus_ad_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mux_byte_writer u_mux_byte_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .cfg_dur(cfg_dur), .cfg_hold(cfg_hold),
        .cfg_flash(cfg_flash), .cfg_ale_low(cfg_ale_low), .busy(busy),
        .done(done), .err(err), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ale(bus_ale), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one legal write; every cycle is compared with a timeline built from D, F, H
    task automatic run_write(input string tag, input logic [15:0] a, input logic [31:0] d,
                             input int dur, input bit hold, input bit flash,
                             input bit intrude);
        int f, h, w, p, t_end;
        bit ok;
        f = flash ? 7 : 0;
        h = hold ? 1 : 0;
        w = dur - f;
        p = w + h + f + 1;
        t_end = 4 + 3*p + w + h;
        ok = 1;
        @(negedge clk);
        req_addr = a; req_data = d; cfg_dur = 5'(dur);
        cfg_hold = hold; cfg_flash = flash; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t <= t_end + 1; t++) begin
            logic        e_act, e_oe, e_wr_n, e_done;
            logic [15:0] e_ad;
            int rel, b;
            e_act  = (t < 2);
            e_oe   = (t < t_end);
            e_done = (t == t_end);
            e_wr_n = 1'b1;
            e_ad   = '0;
            if (t < 3) e_ad = a;
            else if (t < t_end) begin
                rel = t - 4;
                b = (rel + f + 1) / p;
                if (b > 3) b = 3;
                e_ad = {a[15:8], d[8*b +: 8]};
                if (rel >= 0 && (rel % p) < w && (rel / p) <= 3) e_wr_n = 1'b0;
            end
            if (bus_ale !== (e_act ^ cfg_ale_low) || bus_ad_out !== e_ad ||
                bus_ad_oe !== e_oe || bus_wr_n !== e_wr_n || busy !== e_oe ||
                done !== e_done || bus_rd_n !== 1'b1 || err !== 1'b0) begin
                ok = 0;
                n_fail++;
                $display("FAIL R2-R8/R11 %s t=%0d: actual ale=%b ad=%h oe=%b wr_n=%b busy=%b done=%b rd_n=%b expected ale=%b ad=%h oe=%b wr_n=%b done=%b",
                         tag, t, bus_ale, bus_ad_out, bus_ad_oe, bus_wr_n, busy, done, bus_rd_n,
                         e_act ^ cfg_ale_low, e_ad, e_oe, e_wr_n, e_done);
            end
            n_checks++;
            if (intrude && t == 6) begin
                req_addr = ~a; req_data = ~d; req_valid = 1'b1;   // R12 stimulus
            end
            if (intrude && t == 7) begin
                req_valid = 1'b0; req_addr = a; req_data = d;
            end
            @(negedge clk);
        end
        check("R8", {tag, " idle after done"}, {31'b0, busy}, 32'd0);
    endtask

    task automatic run_illegal(input string tag, input int dur, input bit flash);
        @(negedge clk);
        cfg_dur = 5'(dur); cfg_flash = flash; req_addr = 16'hBEEF; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10", {tag, " err"}, {31'b0, err}, 32'd1);
        check("R10", {tag, " no bus"}, {busy, bus_ad_oe, bus_wr_n, bus_ale ^ cfg_ale_low},
              {1'b0, 1'b0, 1'b1, 1'b0});
        @(negedge clk);
        check("R10", {tag, " err single"}, {err, busy, bus_ad_oe}, 3'b000);
        cfg_flash = 1'b0;
    endtask

    task automatic test_reset;
        check("R1", "reset outputs",
              {busy, done, err, bus_wr_n, bus_rd_n, bus_ad_oe, bus_ale},
              {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0});
        check("R1", "reset ad", {16'b0, bus_ad_out}, 32'd0);
    endtask

    task automatic test_polarity;
        @(negedge clk);
        cfg_ale_low = 1'b1;
        @(negedge clk);
        check("R9", "idle level active-low", {31'b0, bus_ale}, 32'd1);
        run_write("R9 active-low", 16'h5A3C, 32'h0BADF00D, 4, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        cfg_ale_low = 1'b0;
        @(negedge clk);
        check("R9", "idle level active-high", {31'b0, bus_ale}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_write("R4 basic", 16'h1234, 32'hA1B2C3D4, 3, 1'b0, 1'b0, 1'b0);
        run_write("R6 hold", 16'hC0DE, 32'h11223344, 5, 1'b1, 1'b0, 1'b0);
        run_write("R4 min dur", 16'h00FF, 32'hDEADBEEF, 2, 1'b0, 1'b0, 1'b0);
        run_write("R7 flash", 16'h8001, 32'hCAFEBABE, 9, 1'b1, 1'b1, 1'b0);
        run_write("R7 flash nohold", 16'h7E7E, 32'h01020304, 9, 1'b0, 1'b1, 1'b0);
        run_write("R5 back2back", 16'hFFFF, 32'h80402010, 3, 1'b1, 1'b0, 1'b0);
        run_write("R12 intrude", 16'h4242, 32'h55AA33CC, 4, 1'b1, 1'b0, 1'b1);
        test_polarity();
        run_illegal("R10 dur1", 1, 1'b0);
        run_illegal("R10 dur0", 0, 1'b0);
        run_illegal("R10 flash dur5", 5, 1'b1);
        run_write("R10 legal after err", 16'h0102, 32'h0F1E2D3C, 3, 1'b0, 1'b0, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule